// File: doc/BRIEF.md
# Hashed Page Table Walker

This block looks up a virtual page in a hashed page table held in ordinary memory. The caller supplies a segment identifier, an effective address and a flag for store accesses. The walker derives a tag and a hash from them and reads through one 64-byte group of eight 8-byte entries. If nothing in that group matches, it reads through a second group found from the complemented hash. The table base and size mask are static configuration inputs.

On a hit the walker returns the entry's offset inside the table, both entry words and the translated real address. It then sets the entry's referenced status bit and, on a store, its changed status bit. Each bit is set with a single-byte write to memory; no read-modify-write lock is used. Permission evaluation and fault reporting belong to the caller.

All memory traffic goes through one request port. The port takes word reads and byte writes, and holds each request until it is acknowledged.

Top module: `hpt_walker`

## Requirements
- R1: The page index is `eff_addr[27:12]`. An entry word 0 matches when bit 31 (valid) is 1, bit 6 (hash select) equals the current pass (0 primary, 1 secondary), bits 30:7 equal `seg_vsid`, and bits 5:0 equal page index bits 15:10.
- R2: The primary hash is `seg_vsid[18:0]` XOR the zero-extended page index. The group offset is (hash × 64) AND `tbl_mask`. Entry i of a group is read from `tbl_base` + group offset + 8·i, with word 0 at +0 and word 1 at +4.
- R3: Entries are read in increasing slot order and the first match wins. Word 0 of an entry is read before its word 1, and word 1 is read only for the matching entry.
- R4: The secondary pass runs only after all eight primary entries miss. It uses the full-width bitwise complement of the hash, shifted and masked the same way. Entries whose hash-select bit does not equal the current pass never match.
- R5: When both passes miss, `done` pulses with `found` = 0 and no memory write is issued.
- R6: On a hit whose word 1 bit 8 (referenced) is 0, one byte is written at entry offset +6 with value word1[15:8] OR 0x01. If bit 8 is already 1, no such write is made.
- R7: On a store hit whose word 1 bit 7 (changed) is 0, one byte is written at entry offset +7 with value word1[7:0] OR 0x80. This write comes after any referenced-bit write. Loads never issue it.
- R8: On a hit, `pte_off` is the table-relative entry offset and `pte_w0`/`pte_w1` are the words as read. `real_addr` is word1[31:12] joined with `eff_addr[11:0]`.
- R9: `done` is high for exactly one cycle per accepted `start`. `start` is ignored while `busy` is high.
- R10: `mem_req` stays high with a stable address and direction until `mem_ack`. Reads are word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (sampled when idle) |
| is_store | input | 1 | Access is a store |
| seg_vsid | input | 24 | Segment identifier |
| eff_addr | input | 32 | Effective address |
| tbl_base | input | 32 | Physical base of the table (64-byte aligned) |
| tbl_mask | input | 32 | Table size mask applied to group offsets |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = byte write, 0 = word read |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 32 | Read word, valid with mem_ack |
| mem_ack | input | 1 | Request accepted/completed |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Hit flag, valid with done |
| pte_off | output | 32 | Entry offset within the table |
| pte_w0 | output | 32 | Entry word 0 |
| pte_w1 | output | 32 | Entry word 1 as read |
| real_addr | output | 32 | Translated real address |

## Verification
Several properties are checked on every cycle: the done pulse lasts one cycle, a request holds until it is acknowledged, reads are aligned, and writes land only at entry offsets +6 and +7 with the status bit set in the written byte. Other behaviours can only be shown by the bench's table contents. These are the hash and group arithmetic, the slot order and first-match rule, the fallback to the secondary group, the hash-select filter, and whether each status write is made. The scoreboard checks them against a model of the table built independently of the design, and afterwards reads back the updated entry words from the bench memory.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
   localparam int WORD_W    = 32;
   localparam int PAGE_LOG2 = 12;
   localparam int SEG_LOG2  = 28;
   localparam int W0_VALID  = 31;
   localparam int W1_REF    = 8;
   localparam int W1_CHG    = 7;
   localparam int W1_OFS    = 4;
   localparam int REF_OFS   = 6;
   localparam int CHG_OFS   = 7;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RD_W0, ST_RD_W1, ST_SET_REF, ST_SET_CHG, ST_FIN
   } walk_st_t;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
   parameter int ADDR_W   = 32,
   parameter int VSID_W   = 24,
   parameter int HASH_W   = 19,
   parameter int PIDX_W   = 16,
   parameter int GRP_LOG2 = 6
) (
   input  logic [VSID_W-1:0] vsid,
   input  logic [PIDX_W-1:0] pidx,
   input  logic              sec,
   input  logic [ADDR_W-1:0] mask,
   output logic [ADDR_W-1:0] grp_off
);
   logic [HASH_W-1:0] hash;
   logic [ADDR_W-1:0] hash_x;

   generate
      if (HASH_W < PIDX_W) begin : g_bad_hash
         $error("hpt_hash: HASH_W must cover the page index");
      end
      if (HASH_W + GRP_LOG2 > ADDR_W) begin : g_bad_addr
         $error("hpt_hash: shifted hash exceeds address width");
      end
      if (HASH_W > VSID_W) begin : g_bad_vsid
         $error("hpt_hash: HASH_W exceeds segment identifier width");
      end
   endgenerate

   assign hash    = vsid[HASH_W-1:0] ^ HASH_W'(pidx);
   assign hash_x  = sec ? ~ADDR_W'(hash) : ADDR_W'(hash);
   assign grp_off = (hash_x << GRP_LOG2) & mask;
endmodule

// File: rtl/hpt_match.sv
module hpt_match #(
   parameter int WORD_W = 32,
   parameter int VSID_W = 24,
   parameter int API_W  = 6
) (
   input  logic [WORD_W-1:0] word0,
   input  logic [VSID_W-1:0] vsid,
   input  logic [API_W-1:0]  api,
   input  logic              sec,
   output logic              hit
);
   generate
      if (2 + VSID_W + API_W != WORD_W) begin : g_bad_layout
         $error("hpt_match: entry word 0 fields do not fill the word");
      end
   endgenerate

   assign hit = word0[WORD_W-1]
             && (word0[API_W] == sec)
             && (word0[WORD_W-2 -: VSID_W] == vsid)
             && (word0[API_W-1:0] == api);
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
   import hpt_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int EA_W          = 32,
   parameter int VSID_W        = 24,
   parameter int HASH_W        = 19,
   parameter int GROUP_ENTRIES = 8,
   parameter int ENTRY_BYTES   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_store,
   input  logic [VSID_W-1:0] seg_vsid,
   input  logic [EA_W-1:0]   eff_addr,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic [ADDR_W-1:0] tbl_mask,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              mem_ack,
   output logic              busy,
   output logic              done,
   output logic              found,
   output logic [ADDR_W-1:0] pte_off,
   output logic [WORD_W-1:0] pte_w0,
   output logic [WORD_W-1:0] pte_w1,
   output logic [ADDR_W-1:0] real_addr
);
   localparam int PIDX_W   = SEG_LOG2 - PAGE_LOG2;
   localparam int API_W    = WORD_W - 2 - VSID_W;
   localparam int IDX_W    = $clog2(GROUP_ENTRIES);
   localparam int ENT_LOG2 = $clog2(ENTRY_BYTES);
   localparam int GRP_LOG2 = $clog2(GROUP_ENTRIES * ENTRY_BYTES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

   generate
      if (EA_W < SEG_LOG2) begin : g_bad_ea
         $error("hpt_walker: effective address narrower than a segment");
      end
      if (ADDR_W < WORD_W) begin : g_bad_pa
         $error("hpt_walker: address narrower than entry word");
      end
      if ((1 << GRP_LOG2) != GROUP_ENTRIES * ENTRY_BYTES) begin : g_bad_grp
         $error("hpt_walker: group size must be a power of two");
      end
      if (ENTRY_BYTES < CHG_OFS + 1) begin : g_bad_ent
         $error("hpt_walker: entry too small for status bytes");
      end
   endgenerate

   walk_st_t                st_q;
   logic [VSID_W-1:0]       vsid_q;
   logic [PIDX_W-1:0]       pidx_q;
   logic [PAGE_LOG2-1:0]    poff_q;
   logic                    store_q;
   logic                    pass_q;
   logic [IDX_W-1:0]        idx_q;
   logic                    found_q;
   logic [ADDR_W-1:0]       off_q;
   logic [WORD_W-1:0]       w0_q, w1_q;

   logic [ADDR_W-1:0]       grp_off;
   logic [ADDR_W-1:0]       entry_off;
   logic                    hit;

   hpt_hash #(
      .ADDR_W(ADDR_W), .VSID_W(VSID_W), .HASH_W(HASH_W),
      .PIDX_W(PIDX_W), .GRP_LOG2(GRP_LOG2)
   ) u_hash (
      .vsid(vsid_q), .pidx(pidx_q), .sec(pass_q),
      .mask(tbl_mask), .grp_off(grp_off)
   );

   hpt_match #(
      .WORD_W(WORD_W), .VSID_W(VSID_W), .API_W(API_W)
   ) u_match (
      .word0(mem_rdata), .vsid(vsid_q), .api(pidx_q[PIDX_W-1 -: API_W]),
      .sec(pass_q), .hit(hit)
   );

   assign entry_off = grp_off + (ADDR_W'(idx_q) << ENT_LOG2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         vsid_q  <= '0;
         pidx_q  <= '0;
         poff_q  <= '0;
         store_q <= 1'b0;
         pass_q  <= 1'b0;
         idx_q   <= '0;
         found_q <= 1'b0;
         off_q   <= '0;
         w0_q    <= '0;
         w1_q    <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               vsid_q  <= seg_vsid;
               pidx_q  <= eff_addr[SEG_LOG2-1:PAGE_LOG2];
               poff_q  <= eff_addr[PAGE_LOG2-1:0];
               store_q <= is_store;
               pass_q  <= 1'b0;
               idx_q   <= '0;
               found_q <= 1'b0;
               st_q    <= ST_RD_W0;
            end
            ST_RD_W0: if (mem_ack) begin
               w0_q <= mem_rdata;
               if (hit) begin
                  off_q <= entry_off;
                  st_q  <= ST_RD_W1;
               end else if (idx_q == LAST_IDX) begin
                  idx_q <= '0;
                  if (!pass_q) pass_q <= 1'b1;
                  else         st_q   <= ST_FIN;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_RD_W1: if (mem_ack) begin
               w1_q    <= mem_rdata;
               found_q <= 1'b1;
               if (!mem_rdata[W1_REF])                  st_q <= ST_SET_REF;
               else if (store_q && !mem_rdata[W1_CHG])  st_q <= ST_SET_CHG;
               else                                     st_q <= ST_FIN;
            end
            ST_SET_REF: if (mem_ack) begin
               st_q <= (store_q && !w1_q[W1_CHG]) ? ST_SET_CHG : ST_FIN;
            end
            ST_SET_CHG: if (mem_ack) st_q <= ST_FIN;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b1;
      mem_we    = 1'b0;
      mem_wdata = 8'h00;
      mem_addr  = tbl_base + off_q;
      case (st_q)
         ST_RD_W0:   mem_addr = tbl_base + entry_off;
         ST_RD_W1:   mem_addr = tbl_base + off_q + ADDR_W'(W1_OFS);
         ST_SET_REF: begin
            mem_we    = 1'b1;
            mem_addr  = tbl_base + off_q + ADDR_W'(REF_OFS);
            mem_wdata = w1_q[15:8] | 8'h01;
         end
         ST_SET_CHG: begin
            mem_we    = 1'b1;
            mem_addr  = tbl_base + off_q + ADDR_W'(CHG_OFS);
            mem_wdata = w1_q[7:0] | 8'h80;
         end
         default:    mem_req = 1'b0;
      endcase
   end

   assign busy      = (st_q != ST_IDLE);
   assign done      = (st_q == ST_FIN);
   assign found     = found_q;
   assign pte_off   = off_q;
   assign pte_w0    = w0_q;
   assign pte_w1    = w1_q;
   assign real_addr = ADDR_W'({w1_q[WORD_W-1:PAGE_LOG2], poff_q});
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [7:0]        mem_wdata,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] tbl_base,
   input logic              busy,
   input logic              done
);
   logic [ADDR_W-1:0] rel;
   assign rel = mem_addr - tbl_base;

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
   p_read_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (mem_addr[1:0] == 2'b00));
   p_wr_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (rel[2:1] == 2'b11));
   p_ref_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && rel[2:0] == 3'd6) |-> mem_wdata[0]);
   p_chg_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && rel[2:0] == 3'd7) |-> mem_wdata[7]);
endmodule

bind hpt_walker hpt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
   .tbl_base(tbl_base), .busy(busy), .done(done)
);

// File: tb/hpt_walker_test.sv
`timescale 1ns/1ps
module hpt_walker_test;
   localparam logic [31:0] BASE = 32'h0001_0000;
   localparam logic [31:0] MASK = 32'h0000_3FC0;

   typedef struct {
      logic        fnd;
      logic [31:0] off, w0, w1, ra;
      int          nwr, wbase;
   } exp_t;

   logic clk = 0, rst_n = 0;
   logic start = 0, is_store = 0;
   logic [23:0] seg_vsid = '0;
   logic [31:0] eff_addr = '0;
   logic mem_req, mem_we, mem_ack = 0, busy, done, found;
   logic [31:0] mem_addr, mem_rdata = '0, pte_off, pte_w0, pte_w1, real_addr;
   logic [7:0] mem_wdata;

   logic [31:0] mem [0:4095];
   logic clr = 0, poke = 0;
   logic [11:0] poke_idx = '0;
   logic [31:0] poke_data = '0;
   int wr_cnt = 0, done_cnt = 0, total = 0, fails = 0;
   exp_t exp_q[$];

   always #2 clk = ~clk;

   hpt_walker uut (
      .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
      .seg_vsid(seg_vsid), .eff_addr(eff_addr), .tbl_base(BASE), .tbl_mask(MASK),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy), .done(done),
      .found(found), .pte_off(pte_off), .pte_w0(pte_w0), .pte_w1(pte_w1),
      .real_addr(real_addr)
   );

   // memory model: one-cycle acknowledge, big-endian byte lanes
   always @(posedge clk) begin
      logic [31:0] rel;
      rel = mem_addr - BASE;
      if (clr) for (int i = 0; i < 4096; i++) mem[i] <= '0;
      else if (poke) mem[poke_idx] <= poke_data;
      if (!rst_n) mem_ack <= 1'b0;
      else if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) begin
            case (rel[1:0])
               2'd0: mem[rel[13:2]][31:24] <= mem_wdata;
               2'd1: mem[rel[13:2]][23:16] <= mem_wdata;
               2'd2: mem[rel[13:2]][15:8]  <= mem_wdata;
               default: mem[rel[13:2]][7:0] <= mem_wdata;
            endcase
            wr_cnt <= wr_cnt + 1;
         end else mem_rdata <= mem[rel[13:2]];
      end else mem_ack <= 1'b0;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) check("R9 unexpected done", 32'd1, 32'd0);
         else begin
            exp_t e;
            e = exp_q.pop_front();
            check("R5/R8 found", 32'(found), 32'(e.fnd));
            if (e.fnd) begin
               check("R2/R3/R4 pte_off", pte_off, e.off);
               check("R8 pte_w0", pte_w0, e.w0);
               check("R8 pte_w1", pte_w1, e.w1);
               check("R8 real_addr", real_addr, e.ra);
            end
            check("R5/R6/R7 write count", 32'(wr_cnt - e.wbase), 32'(e.nwr));
         end
         done_cnt++;
      end
   end

   function automatic logic [31:0] grp(input logic [23:0] v, input logic [31:0] ea, input logic sec);
      logic [18:0] h;
      logic [31:0] hx;
      h  = v[18:0] ^ {3'b000, ea[27:12]};
      hx = sec ? ~{13'b0, h} : {13'b0, h};
      return (hx << 6) & MASK;
   endfunction

   function automatic logic [31:0] mk_w0(input logic [23:0] v, input logic sec, input logic [31:0] ea);
      return {1'b1, v, sec, ea[27:22]};
   endfunction

   task automatic put_word(input logic [31:0] rel, input logic [31:0] d);
      @(negedge clk);
      poke = 1; poke_idx = rel[13:2]; poke_data = d;
      @(negedge clk);
      poke = 0;
   endtask

   task automatic put_pte(input logic [31:0] off, input logic [31:0] w0, input logic [31:0] w1);
      put_word(off, w0);
      put_word(off + 4, w1);
   endtask

   task automatic clear_mem();
      @(negedge clk); clr = 1;
      @(negedge clk); clr = 0;
   endtask

   task automatic walk(input logic [23:0] v, input logic [31:0] ea, input logic st,
                       input logic fnd, input logic [31:0] off, input logic [31:0] w1,
                       input int nwr, input bit poke_busy);
      exp_t e;
      int target;
      e.fnd = fnd; e.off = off; e.w0 = mk_w0(v, off[30] ? 1'b0 : e.fnd & 1'b0, ea);
      e.w1 = w1; e.ra = {w1[31:12], ea[11:0]}; e.nwr = nwr; e.wbase = wr_cnt;
      e.w0 = mem[off[13:2]];
      exp_q.push_back(e);
      target = done_cnt + 1;
      @(negedge clk);
      seg_vsid = v; eff_addr = ea; is_store = st; start = 1;
      @(negedge clk);
      start = 0;
      if (poke_busy) begin
         repeat (3) @(negedge clk);
         check("R9 busy during walk", 32'(busy), 32'd1);
         seg_vsid = ~v; eff_addr = ~ea; start = 1;
         @(negedge clk);
         start = 0;
      end
      wait (done_cnt == target);
      @(negedge clk);
   endtask

   localparam logic [23:0] V1 = 24'h012345;
   localparam logic [31:0] E1 = 32'h3ABC_D123;

   initial begin
      logic [31:0] g0, g1;
      repeat (3) @(negedge clk);
      check("R9 reset done", 32'(done), 32'd0);
      check("R10 reset mem_req", 32'(mem_req), 32'd0);
      check("R9 reset busy", 32'(busy), 32'd0);
      rst_n = 1;

      // R1/R6: primary hit in slot 3, load, referenced bit clear
      g0 = grp(V1, E1, 0);
      clear_mem();
      put_pte(g0 + 0, mk_w0(V1, 0, E1) & 32'h7FFF_FFFF, 32'hDEAD_0000);
      put_pte(g0 + 8, mk_w0(V1, 0, E1) ^ 32'h1, 32'hBEEF_0000);
      put_pte(g0 + 24, mk_w0(V1, 0, E1), 32'hABCD_E012);
      walk(V1, E1, 0, 1, g0 + 24, 32'hABCD_E012, 1, 0);
      check("R6 ref byte", mem[(g0 + 28) >> 2], 32'hABCD_E112);

      // R7: store, referenced set, changed clear
      clear_mem();
      put_pte(g0, mk_w0(V1, 0, E1), 32'h1111_1100);
      walk(V1, E1, 1, 1, g0, 32'h1111_1100, 1, 0);
      check("R7 chg byte", mem[(g0 + 4) >> 2], 32'h1111_1180);

      // R6/R7: store, both clear
      clear_mem();
      put_pte(g0 + 56, mk_w0(V1, 0, E1), 32'h2222_2002);
      walk(V1, E1, 1, 1, g0 + 56, 32'h2222_2002, 2, 0);
      check("R6/R7 both bytes", mem[(g0 + 60) >> 2], 32'h2222_2182);

      // R7: load with changed clear -> no writes; R6: store with both set -> none
      clear_mem();
      put_pte(g0 + 16, mk_w0(V1, 0, E1), 32'h3333_3102);
      walk(V1, E1, 0, 1, g0 + 16, 32'h3333_3102, 0, 0);
      check("R7 load no chg", mem[(g0 + 20) >> 2], 32'h3333_3102);
      put_pte(g0 + 16, mk_w0(V1, 0, E1), 32'h4444_4186);
      walk(V1, E1, 1, 1, g0 + 16, 32'h4444_4186, 0, 0);

      // R4: secondary pass; primary slot holds a hash-select=1 entry
      g1 = grp(V1, E1, 1);
      clear_mem();
      put_pte(g0, mk_w0(V1, 1, E1), 32'h5555_5100);
      put_pte(g1 + 40, mk_w0(V1, 1, E1), 32'h6666_6100);
      walk(V1, E1, 0, 1, g1 + 40, 32'h6666_6100, 0, 0);

      // R4: last slot of the secondary group with a different segment
      g0 = grp(24'hFABCDE, 32'h0765_4FFF, 0);
      g1 = grp(24'hFABCDE, 32'h0765_4FFF, 1);
      clear_mem();
      put_pte(g1 + 56, mk_w0(24'hFABCDE, 1, 32'h0765_4FFF), 32'h7777_7180);
      walk(24'hFABCDE, 32'h0765_4FFF, 1, 1, g1 + 56, 32'h7777_7180, 0, 0);

      // R5: miss; secondary group only has a hash-select=0 entry
      g1 = grp(V1, E1, 1);
      clear_mem();
      put_pte(g1, mk_w0(V1, 0, E1), 32'h8888_8000);
      walk(V1, E1, 1, 0, 32'h0, 32'h0, 0, 0);
      check("R5 no write on miss", mem[(g1 + 4) >> 2], 32'h8888_8000);

      // R3: two matches, first slot taken; R9: start while busy ignored
      g0 = grp(V1, E1, 0);
      clear_mem();
      put_pte(g0 + 16, mk_w0(V1, 0, E1), 32'h9999_9100);
      put_pte(g0 + 48, mk_w0(V1, 0, E1), 32'hAAAA_A100);
      walk(V1, E1, 0, 1, g0 + 16, 32'h9999_9100, 0, 1);
      repeat (10) @(negedge clk);
      check("R9 single done", 32'(done_cnt), 32'd9);
      check("R9 idle after walk", 32'(busy), 32'd0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule